// File: doc/BRIEF.md
# Single-Register I2C Control/Status Target

This block is an I2C target for a device that exposes exactly one writable control byte and one readable status byte. SCL and SDA arrive as raw, oversampled levels. Each passes through a two-flop synchronizer and then an edge detector that reports SCL rising and falling edges and the Start and Stop conditions. SDA is driven through an open-drain enable: a high `sda_oe` pulls the line low. The seven-bit device address has a fixed upper prefix `00010`. Its low two bits come from a strap input, so up to four such devices can share one bus.

A write transaction carries three bytes: the device address with R/W=0, a register-address byte that must be 0x00, and the control value. The control value reaches `ctrl_out` when the acknowledge clock of the data byte completes, together with a one-cycle strobe. A status read takes two transactions. The first writes the register address 0x00 and ends with a Stop. The second opens with a Start and the address with R/W=1. The target then shifts out a snapshot of `status_in`, MSB first, and lets go of SDA for the master's acknowledge.

Top module: `ctrlstat_i2c_target`

## Requirements
- R1: While `rst_n` is low, `ctrl_out` is 0x00, `ctrl_wr` is 0 and `sda_oe` is 0 (SDA released).
- R2: The address byte is received MSB first as seven address bits followed by R/W. It matches when those seven bits equal `00010` followed by `strap[1:0]`. On a match the target holds `sda_oe`=1 (ACK, line low) from the falling SCL edge after the eighth bit until the falling edge that ends the ninth clock.
- R3: A mismatched address is not acknowledged. All bytes that follow are ignored, with SDA left released and `ctrl_out` unchanged, until the next Start.
- R4: In a write, a register address of 0x00 and the data byte are each acknowledged. `ctrl_out` takes the data byte, and `ctrl_wr` is high for exactly one clock, both registered on the falling SCL edge that closes the data byte's acknowledge clock.
- R5: A register address other than 0x00 is not acknowledged. The data byte that follows gets no ACK and leaves `ctrl_out` and `ctrl_wr` unchanged.
- R6: After an acknowledged address with R/W=1, the target places the status bits on SDA, MSB first. Bit 7 appears at the falling edge that ends the address ACK clock, and each later bit appears at the following falling edge. A 0 bit is sent as `sda_oe`=1 and a 1 bit as `sda_oe`=0.
- R7: `status_in` is sampled once, at the falling edge after the eighth bit of a matching read address. Later changes to `status_in` do not alter the byte being sent.
- R8: From the falling edge after the eighth status bit, SDA stays released through the master's acknowledge clock and any further clocks until the next Start.
- R9: A Start or Stop in the middle of a byte abandons it. A Stop inside a data byte leaves `ctrl_out` unchanged, and a Start restarts address reception with a zeroed bit count.
- R10: `sda_oe` changes only in the clock after a detected SCL falling edge, Start or Stop, so the target never moves SDA while SCL is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| strap | input | 2 | Low two bits of the device address |
| status_in | input | 8 | Status byte returned on reads |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| ctrl_out | output | 8 | Control register contents |
| ctrl_wr | output | 1 | One-clock pulse when the control register is written |

## Verification
Every bus input runs through two synchronizer flops and one state register. Any response to a change of SCL or SDA is therefore due at the third rising clock edge after the bench drives that change. The bench drives the master's intended result at each bus edge into an ideal value. It delays this value by three rising edges and compares `sda_oe`, `ctrl_out` and `ctrl_wr` against it at every falling clock edge. The bench also samples the read bits on the wired-AND line at the middle of each high SCL phase, well after that pipeline has settled.

// File: rtl/ctrlstat_pkg.sv
package ctrlstat_pkg;
    localparam int BYTE_W   = 8;
    localparam int DEV_AW   = 7;
    localparam int CNT_W    = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] ACK_END  = CNT_W'(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_REG,
        ST_WDATA,
        ST_SEND,
        ST_SKIP
    } phase_t;

    typedef struct packed {
        phase_t              st;
        logic [CNT_W-1:0]    bitc;
        logic [BYTE_W-1:0]   sh;
        logic                rw;
        logic                oe;
        logic [BYTE_W-1:0]   ctrl;
        logic                wr;
    } core_t;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
    parameter int             W      = 2,
    parameter int             STAGES = 2,
    parameter logic [W-1:0]   INIT   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= INIT;
                else        stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= INIT;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bus_events.sv
module bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d    = scl_s;
        sda_d    = sda_s;
        scl_rise = scl_s & ~scl_q;
        scl_fall = ~scl_s & scl_q;
        start_ev = scl_s & scl_q & sda_q & ~sda_s;
        stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end
endmodule

// File: rtl/ctrlstat_core.sv
module ctrlstat_core
    import ctrlstat_pkg::*;
#(
    parameter int                         STRAP_W = 2,
    parameter logic [DEV_AW-STRAP_W-1:0]  PREFIX  = 5'b00010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               start_ev,
    input  logic               stop_ev,
    input  logic               sda_s,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  status_in,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  ctrl_out,
    output logic               ctrl_wr
);
    core_t q, n;
    logic  addr_hit;
    logic  active;

    always_comb begin
        addr_hit = (q.sh[BYTE_W-1 -: DEV_AW] == {PREFIX, strap});
        active   = (q.st == ST_ADDR) || (q.st == ST_REG) ||
                   (q.st == ST_WDATA) || (q.st == ST_SEND);
        n        = q;
        n.wr     = 1'b0;
        if (start_ev) begin
            n.st   = ST_ADDR;
            n.bitc = '0;
            n.oe   = 1'b0;
        end else if (stop_ev) begin
            n.st   = ST_IDLE;
            n.bitc = '0;
            n.oe   = 1'b0;
        end else if (active) begin
            if (scl_rise) begin
                if (q.bitc < LAST_BIT && q.st != ST_SEND)
                    n.sh = {q.sh[BYTE_W-2:0], sda_s};
                if (q.bitc != ACK_END)
                    n.bitc = q.bitc + 1'b1;
            end else if (scl_fall) begin
                if (q.st == ST_SEND) begin
                    if (q.bitc == LAST_BIT) begin
                        n.oe = 1'b0;
                        n.st = ST_SKIP;
                    end else if (q.bitc != '0) begin
                        n.sh = {q.sh[BYTE_W-2:0], 1'b0};
                        n.oe = ~q.sh[BYTE_W-2];
                    end
                end else if (q.bitc == LAST_BIT) begin
                    case (q.st)
                        ST_ADDR: begin
                            if (addr_hit) begin
                                n.oe = 1'b1;
                                n.rw = q.sh[0];
                                if (q.sh[0]) n.sh = status_in;
                            end else begin
                                n.st = ST_SKIP;
                            end
                        end
                        ST_REG: begin
                            if (q.sh == '0) n.oe = 1'b1;
                            else            n.st = ST_SKIP;
                        end
                        default: n.oe = 1'b1;
                    endcase
                end else if (q.bitc == ACK_END) begin
                    n.oe   = 1'b0;
                    n.bitc = '0;
                    case (q.st)
                        ST_ADDR: begin
                            if (q.rw) begin
                                n.st = ST_SEND;
                                n.oe = ~q.sh[BYTE_W-1];
                            end else begin
                                n.st = ST_REG;
                            end
                        end
                        ST_REG:  n.st = ST_WDATA;
                        default: begin
                            n.ctrl = q.sh;
                            n.wr   = 1'b1;
                            n.st   = ST_SKIP;
                        end
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.bitc <= '0;
            q.sh   <= '0;
            q.rw   <= 1'b0;
            q.oe   <= 1'b0;
            q.ctrl <= '0;
            q.wr   <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign sda_oe   = q.oe;
    assign ctrl_out = q.ctrl;
    assign ctrl_wr  = q.wr;
endmodule

// File: rtl/ctrlstat_i2c_target.sv
module ctrlstat_i2c_target
    import ctrlstat_pkg::*;
#(
    parameter int                         STRAP_W     = 2,
    parameter int                         SYNC_STAGES = 2,
    parameter logic [DEV_AW-STRAP_W-1:0]  PREFIX      = 5'b00010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap,
    input  logic [BYTE_W-1:0]  status_in,
    output logic               sda_oe,
    output logic [BYTE_W-1:0]  ctrl_out,
    output logic               ctrl_wr
);
    logic [1:0] line_s;
    logic       scl_rise, scl_fall, start_ev, stop_ev;

    bus_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (line_s)
    );

    bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (line_s[1]),
        .sda_s    (line_s[0]),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    ctrlstat_core #(.STRAP_W(STRAP_W), .PREFIX(PREFIX)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .sda_s     (line_s[0]),
        .strap     (strap),
        .status_in (status_in),
        .sda_oe    (sda_oe),
        .ctrl_out  (ctrl_out),
        .ctrl_wr   (ctrl_wr)
    );
endmodule

// File: rtl/ctrlstat_chk.sv
module ctrlstat_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic [7:0] ctrl_out,
    input logic       ctrl_wr,
    input logic       scl_fall,
    input logic       start_ev,
    input logic       stop_ev
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_vals_r1: assert (ctrl_out == 8'h00 && !sda_oe && !ctrl_wr)
                else $error("reset values wrong");
        end
    end

    p_wr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !ctrl_wr);

    p_wr_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |-> $past(scl_fall));

    p_ctrl_only_on_wr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_out) |-> ctrl_wr);

    p_start_releases_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> !sda_oe);

    p_oe_moves_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));
endmodule

bind ctrlstat_i2c_target ctrlstat_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .ctrl_out (ctrl_out),
    .ctrl_wr  (ctrl_wr),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
);

// File: tb/sim_ctrlstat_i2c_target.sv
module sim_ctrlstat_i2c_target;
    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap = 2'b01;
    logic [7:0] status_in = 8'h00;
    logic       sda_oe;
    logic [7:0] ctrl_out;
    logic       ctrl_wr;
    logic       sda_line;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur = "R1";

    logic       id_oe = 1'b0;
    logic       id_wr = 1'b0;
    logic [7:0] id_ctrl = 8'h00;
    logic [9:0] pipe [3];

    always #10 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    ctrlstat_i2c_target u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .strap     (strap),
        .status_in (status_in),
        .sda_oe    (sda_oe),
        .ctrl_out  (ctrl_out),
        .ctrl_wr   (ctrl_wr)
    );

    initial begin
        for (int i = 0; i < 3; i++) pipe[i] = 10'd0;
    end

    // reference: ideal response delayed by the three register stages
    always @(posedge clk) begin
        pipe[2] <= pipe[1];
        pipe[1] <= pipe[0];
        pipe[0] <= {id_oe, id_wr, id_ctrl};
    end

    always @(negedge clk) begin
        if (!done) begin
            n_cmp++;
            if ({sda_oe, ctrl_wr, ctrl_out} !== pipe[2]) begin
                n_bad++;
                $display("FAIL %s: oe/wr/ctrl actual %b/%b/%h expected %b/%b/%h at %0t",
                         cur, sda_oe, ctrl_wr, ctrl_out,
                         pipe[2][9], pipe[2][8], pipe[2][7:0], $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b);
        m_sda = b; tick(4);
        m_scl = 1'b1; tick(8);
        m_scl = 1'b0;
    endtask

    task automatic start_c();
        m_sda = 1'b1; tick(2);
        m_scl = 1'b1; tick(6);
        m_sda = 1'b0; id_oe = 1'b0; tick(6);
        m_scl = 1'b0; tick(4);
    endtask

    task automatic stop_c();
        m_sda = 1'b0; tick(4);
        m_scl = 1'b1; tick(6);
        m_sda = 1'b1; id_oe = 1'b0; tick(6);
    endtask

    task automatic wr_byte(input logic [7:0] b, input logic ack,
                           input logic commit, input logic after_oe);
        for (int i = 7; i >= 0; i--) begin
            clk_bit(b[i]);
            if (i == 0) id_oe = ack;
            tick(4);
        end
        clk_bit(1'b1);
        id_oe = after_oe;
        if (commit) begin
            id_ctrl = b;
            id_wr   = 1'b1;
        end
        tick(1);
        id_wr = 1'b0;
        tick(3);
    endtask

    task automatic part_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            clk_bit(b[i]);
            tick(4);
        end
    endtask

    task automatic rd_byte(input logic [7:0] exp, input logic mack,
                           input logic disturb);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(4);
            m_scl = 1'b1; tick(4);
            n_cmp++;
            if (sda_line !== exp[i]) begin
                n_bad++;
                $display("FAIL R6: read bit %0d actual %b expected %b", i, sda_line, exp[i]);
            end
            if (disturb && i == 5) status_in = ~status_in;
            tick(4);
            m_scl = 1'b0;
            id_oe = (i > 0) ? ~exp[i-1] : 1'b0;
            tick(4);
        end
        clk_bit(mack);
        tick(4);
    endtask

    task automatic set_ptr(input logic [6:0] dev);
        start_c();
        wr_byte({dev, 1'b0}, 1'b1, 1'b0, 1'b0);
        wr_byte(8'h00, 1'b1, 1'b0, 1'b0);
        stop_c();
    endtask

    initial begin
        #1 rst_n = 1'b0;
        cur = "R1";
        tick(6);
        rst_n = 1'b1;
        tick(6);

        cur = "R2/R4";
        strap = 2'b01;
        start_c();
        wr_byte(8'b0001_0010, 1'b1, 1'b0, 1'b0);
        wr_byte(8'h00, 1'b1, 1'b0, 1'b0);
        wr_byte(8'hA5, 1'b1, 1'b1, 1'b0);
        stop_c();
        tick(8);

        cur = "R3";
        start_c();
        wr_byte(8'b0001_0100, 1'b0, 1'b0, 1'b0);
        wr_byte(8'h00, 1'b0, 1'b0, 1'b0);
        wr_byte(8'h11, 1'b0, 1'b0, 1'b0);
        stop_c();
        start_c();
        wr_byte(8'b1001_0010, 1'b0, 1'b0, 1'b0);
        wr_byte(8'h22, 1'b0, 1'b0, 1'b0);
        stop_c();
        tick(8);

        cur = "R5";
        start_c();
        wr_byte(8'b0001_0010, 1'b1, 1'b0, 1'b0);
        wr_byte(8'h01, 1'b0, 1'b0, 1'b0);
        wr_byte(8'h66, 1'b0, 1'b0, 1'b0);
        stop_c();
        start_c();
        wr_byte(8'b0001_0010, 1'b1, 1'b0, 1'b0);
        wr_byte(8'h80, 1'b0, 1'b0, 1'b0);
        wr_byte(8'h77, 1'b0, 1'b0, 1'b0);
        stop_c();
        tick(8);

        cur = "R6/R7";
        status_in = 8'h5A;
        set_ptr(7'b0001_001);
        start_c();
        wr_byte(8'b0001_0011, 1'b1, 1'b0, ~status_in[7]);
        rd_byte(8'h5A, 1'b1, 1'b1);
        cur = "R8";
        wr_byte(8'h00, 1'b0, 1'b0, 1'b0);
        stop_c();
        tick(8);

        cur = "R9";
        start_c();
        wr_byte(8'b0001_0010, 1'b1, 1'b0, 1'b0);
        wr_byte(8'h00, 1'b1, 1'b0, 1'b0);
        part_bits(8'h0F, 4);
        stop_c();
        strap = 2'b11;
        start_c();
        part_bits(8'b0001_0110, 3);
        start_c();
        wr_byte(8'b0001_0110, 1'b1, 1'b0, 1'b0);
        wr_byte(8'h00, 1'b1, 1'b0, 1'b0);
        wr_byte(8'h3C, 1'b1, 1'b1, 1'b0);
        stop_c();
        tick(8);

        cur = "R2/R6";
        strap = 2'b10;
        status_in = 8'h00;
        set_ptr(7'b0001_010);
        start_c();
        wr_byte(8'b0001_0101, 1'b1, 1'b0, 1'b1);
        rd_byte(8'h00, 1'b1, 1'b0);
        stop_c();
        status_in = 8'hFF;
        start_c();
        wr_byte(8'b0001_0101, 1'b1, 1'b0, 1'b0);
        rd_byte(8'hFF, 1'b0, 1'b0);
        stop_c();

        cur = "R10";
        start_c();
        wr_byte(8'b0001_0100, 1'b1, 1'b0, 1'b0);
        wr_byte(8'h00, 1'b1, 1'b0, 1'b0);
        wr_byte(8'hC3, 1'b1, 1'b1, 1'b0);
        stop_c();
        tick(10);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule